// File: doc/BRIEF.md
# DMA Interrupt and Channel Status Unit

This unit is the shared event and status block for a multi-channel DMA engine. Every channel reports four kinds of event: transfer complete, source-side bus error, destination-side bus error and bad configuration. Each kind is held in its own pending register, with one bit per channel. A gated view of each register ANDs the pending bits with the per-channel interrupt enables. A single interrupt line is high whenever any enabled bit is pending in any of the four kinds.

Software clears pending bits by writing ones to a pending register. Writing 0xFFFFFFFF to all four pending registers empties the block, which is the usual start-up sequence. The unit also records which channels are running, based on launch, finish and forced-stop pulses from the channel engines. It holds a group-priority value and an arbitration-mode value for the arbiter, which lives outside this block. All registers are reached through a simple register port. Reads return data one clock after the request.

In every register, bit n refers to physical channel n. A word address selects the register:

| Register | Address |
|---|---|
| Gated complete | 0x800 |
| Gated source error | 0x804 |
| Gated destination error | 0x808 |
| Gated configuration error | 0x80C |
| Pending complete | 0x810 |
| Pending source error | 0x814 |
| Pending destination error | 0x818 |
| Pending configuration error | 0x81C |
| Running status | 0x820 |
| Group priority | 0x824 |
| Arbitration mode | 0x828 |

Top module: `dma_irq_status_unit`

## Requirements
- R1: After reset, every pending register, the running status, the group-priority and arbitration values, `reg_rdata` and `irq` are all zero.
- R2: A one on bit n of an event input sets bit n of the matching pending register at the next clock edge. The mapping is: complete to 0x810, source error to 0x814, destination error to 0x818, configuration error to 0x81C. The bit stays set until it is cleared.
- R3: Reading 0x800, 0x804, 0x808 or 0x80C returns the pending register at that address plus 0x10, ANDed with `irq_en`.
- R4: After a clock edge, `irq` is high exactly when at least one pending bit in any of the four kinds is set while the same bit of `irq_en` is set.
- R5: A write to a pending register clears each bit written as one. Bits written as zero keep their value.
- R6: If an event and a clear reach the same bit at the same clock edge, the event wins and the bit stays set.
- R7: Writing all ones to the four pending registers leaves no event pending, and `irq` then drops.
- R8: Bit n of the running status at 0x820 is set after a clock edge with `ch_launch[n]` and cleared after an edge with `ch_finish[n]`. If both arrive at the same edge, launch wins.
- R9: `ch_kill[n]` clears running bit n at the next edge, even if `ch_launch[n]` is high at the same edge.
- R10: 0x824 stores the low PRIO_W bits of the write data and 0x828 stores the low ARB_W bits. Both read back and drive `grp_prio` and `arb_mode`. An arbitration value of 0 means all channels have equal priority.
- R11: Writes to the gated addresses (0x800 to 0x80C) and to the running status (0x820) change nothing.
- R12: `reg_rdata` holds the selected value in the cycle after `reg_rd` is sampled. It is zero for an unmapped address and zero in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, one cycle after `reg_rd` |
| ev_tc | input | N | Per-channel transfer-complete pulses |
| ev_src_err | input | N | Per-channel source-error pulses |
| ev_dst_err | input | N | Per-channel destination-error pulses |
| ev_cfg_err | input | N | Per-channel configuration-error pulses |
| irq_en | input | N | Per-channel interrupt enables |
| ch_launch | input | N | Per-channel start pulses |
| ch_finish | input | N | Per-channel normal-end pulses |
| ch_kill | input | N | Per-channel forced-stop pulses |
| irq | output | 1 | Combined interrupt |
| grp_prio | output | PRIO_W | Stored group-priority value |
| arb_mode | output | ARB_W | Stored arbitration mode |

## Verification
The main collision is a software clear of a pending register meeting a fresh hardware event on the same bit at the same edge. The bench provokes it by driving the write and the event pulse at the same falling edge. It then reads the register back and expects the event bit to still be set, and a second bit that was only cleared to be gone. The running status has a second collision, where launch, finish and kill pulses land on the same channel together. The expected status word in that case comes from the priority order: kill first, then launch over finish.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int NUM_CLASSES = 4;
  localparam logic [11:0] OFF_GATED = 12'h800;
  localparam logic [11:0] OFF_PEND  = 12'h810;
  localparam logic [11:0] OFF_RUN   = 12'h820;
  localparam logic [11:0] OFF_PRIO  = 12'h824;
  localparam logic [11:0] OFF_ARB   = 12'h828;
  localparam int          REG_STEP  = 4;

  typedef enum logic [1:0] {
    EV_DONE    = 2'd0,
    EV_SRC_BAD = 2'd1,
    EV_DST_BAD = 2'd2,
    EV_CFG_BAD = 2'd3
  } ev_kind_e;
endpackage

// File: rtl/dma_evt_bank.sv
module dma_evt_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] gated_o,
  output logic         hit_next_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  always_comb pend_d = (pend_q & ~clr_i) | evt_i;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  assign pend_o     = pend_q;
  assign gated_o    = pend_q & en_i;
  assign hit_next_o = |(pend_d & en_i);

  // R6
  evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

  // R5
  zero_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (|pend_q) |=> ((($past(pend_q) & ~$past(clr_i)) & ~pend_q) == '0));

  // R5
  ones_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & ~evt_i)) |=> ((pend_q & $past(clr_i & ~evt_i)) == '0));
endmodule

// File: rtl/dma_run_track.sv
module dma_run_track #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] launch_i,
  input  logic [N-1:0] finish_i,
  input  logic [N-1:0] kill_i,
  output logic [N-1:0] run_o
);
  logic [N-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= ((run_q & ~finish_i) | launch_i) & ~kill_i;
  end

  assign run_o = run_q;

  // R9
  kill_stops_chk: assert property (@(posedge clk) disable iff (rst)
    (|kill_i) |=> ((run_q & $past(kill_i)) == '0));

  // R8
  launch_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (|(launch_i & ~kill_i)) |=>
      ((run_q & $past(launch_i & ~kill_i)) == $past(launch_i & ~kill_i)));
endmodule

// File: rtl/dma_reg_read.sv
module dma_reg_read
  import dma_irq_pkg::*;
#(
  parameter int N      = 8,
  parameter int DW     = 32,
  parameter int ADDR_W = 12,
  parameter int PRIO_W = 8,
  parameter int ARB_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [NUM_CLASSES-1:0][N-1:0] gated_i,
  input  logic [NUM_CLASSES-1:0][N-1:0] pend_i,
  input  logic [N-1:0]                run_i,
  input  logic [PRIO_W-1:0]           prio_i,
  input  logic [ARB_W-1:0]            arb_i,
  output logic [DW-1:0]               rdata_o
);
  logic [DW-1:0] sel;
  logic [DW-1:0] rdata_q;

  always_comb begin
    sel = '0;
    for (int k = 0; k < NUM_CLASSES; k++) begin
      if (addr_i == ADDR_W'(OFF_GATED) + ADDR_W'(REG_STEP * k)) sel = DW'(gated_i[k]);
      if (addr_i == ADDR_W'(OFF_PEND) + ADDR_W'(REG_STEP * k))  sel = DW'(pend_i[k]);
    end
    if (addr_i == ADDR_W'(OFF_RUN))  sel = DW'(run_i);
    if (addr_i == ADDR_W'(OFF_PRIO)) sel = DW'(prio_i);
    if (addr_i == ADDR_W'(OFF_ARB))  sel = DW'(arb_i);
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= sel;
    else           rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

  // R12
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> (rdata_q == '0));
endmodule

// File: rtl/dma_irq_status_unit.sv
module dma_irq_status_unit
  import dma_irq_pkg::*;
#(
  parameter int N      = 8,
  parameter int DW     = 32,
  parameter int ADDR_W = 12,
  parameter int PRIO_W = 8,
  parameter int ARB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [N-1:0]      ev_tc,
  input  logic [N-1:0]      ev_src_err,
  input  logic [N-1:0]      ev_dst_err,
  input  logic [N-1:0]      ev_cfg_err,
  input  logic [N-1:0]      irq_en,
  input  logic [N-1:0]      ch_launch,
  input  logic [N-1:0]      ch_finish,
  input  logic [N-1:0]      ch_kill,
  output logic              irq,
  output logic [PRIO_W-1:0] grp_prio,
  output logic [ARB_W-1:0]  arb_mode
);
  logic [NUM_CLASSES-1:0][N-1:0] ev_all;
  logic [NUM_CLASSES-1:0][N-1:0] clr_all;
  logic [NUM_CLASSES-1:0][N-1:0] pend_all;
  logic [NUM_CLASSES-1:0][N-1:0] gated_all;
  logic [NUM_CLASSES-1:0]        hit_next;
  logic [N-1:0]                  run;
  logic [PRIO_W-1:0]             prio_q;
  logic [ARB_W-1:0]              arb_q;
  logic                          irq_q;
  logic                          wr_prio;
  logic                          wr_arb;
  logic                          unused_wdata_bits;

  assign unused_wdata_bits = ^reg_wdata;

  assign ev_all[EV_DONE]    = ev_tc;
  assign ev_all[EV_SRC_BAD] = ev_src_err;
  assign ev_all[EV_DST_BAD] = ev_dst_err;
  assign ev_all[EV_CFG_BAD] = ev_cfg_err;

  generate
    for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_kind
      assign clr_all[k] = (reg_wr && reg_addr == ADDR_W'(OFF_PEND) + ADDR_W'(REG_STEP * k))
                          ? reg_wdata[N-1:0] : '0;
      dma_evt_bank #(.N(N)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (ev_all[k]),
        .clr_i      (clr_all[k]),
        .en_i       (irq_en),
        .pend_o     (pend_all[k]),
        .gated_o    (gated_all[k]),
        .hit_next_o (hit_next[k])
      );
    end
  endgenerate

  dma_run_track #(.N(N)) u_run (
    .clk      (clk),
    .rst      (rst),
    .launch_i (ch_launch),
    .finish_i (ch_finish),
    .kill_i   (ch_kill),
    .run_o    (run)
  );

  assign wr_prio = reg_wr && (reg_addr == ADDR_W'(OFF_PRIO));
  assign wr_arb  = reg_wr && (reg_addr == ADDR_W'(OFF_ARB));

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q <= '0;
      arb_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_prio) prio_q <= reg_wdata[PRIO_W-1:0];
      if (wr_arb)  arb_q  <= reg_wdata[ARB_W-1:0];
      irq_q <= |hit_next;
    end
  end

  dma_reg_read #(
    .N(N), .DW(DW), .ADDR_W(ADDR_W), .PRIO_W(PRIO_W), .ARB_W(ARB_W)
  ) u_read (
    .clk     (clk),
    .rst     (rst),
    .rd_i    (reg_rd),
    .addr_i  (reg_addr),
    .gated_i (gated_all),
    .pend_i  (pend_all),
    .run_i   (run),
    .prio_i  (prio_q),
    .arb_i   (arb_q),
    .rdata_o (reg_rdata)
  );

  assign irq      = irq_q;
  assign grp_prio = prio_q;
  assign arb_mode = arb_q;

  // R4
  irq_has_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (|pend_all));

  // R10
  arb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_arb |=> $stable(arb_q));

  // R10
  prio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_prio |=> $stable(prio_q));
endmodule

// File: tb/dma_irq_status_unit_bench.sv
`timescale 1ns/1ps
module dma_irq_status_unit_bench;
  localparam int N = 8;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam int PW = 8;
  localparam int BW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [N-1:0] ev_tc = '0, ev_src_err = '0, ev_dst_err = '0, ev_cfg_err = '0;
  logic [N-1:0] irq_en = '0, ch_launch = '0, ch_finish = '0, ch_kill = '0;
  logic irq;
  logic [PW-1:0] grp_prio;
  logic [BW-1:0] arb_mode;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic rd_seen = 1'b0;
  logic [DW-1:0] q_exp[$];
  string q_tag[$];
  logic [DW-1:0] m_exp;
  string m_tag;
  logic [N-1:0] m_pend[4];
  logic [N-1:0] m_run;

  always #2.5 clk = ~clk;

  dma_irq_status_unit #(.N(N), .DW(DW), .ADDR_W(AW), .PRIO_W(PW), .ARB_W(BW)) u_dma_irq_status_unit (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_tc(ev_tc), .ev_src_err(ev_src_err),
    .ev_dst_err(ev_dst_err), .ev_cfg_err(ev_cfg_err), .irq_en(irq_en), .ch_launch(ch_launch),
    .ch_finish(ch_finish), .ch_kill(ch_kill), .irq(irq), .grp_prio(grp_prio), .arb_mode(arb_mode)
  );

  always @(posedge clk) rd_seen <= reg_rd;

  // monitor: pops expected read data and compares
  always @(negedge clk) begin
    if (rd_seen) begin
      total++;
      if (q_exp.size() == 0) begin
        bad++;
        $display("FAIL R12 unexpected read data got=%h exp=none", reg_rdata);
      end else begin
        m_exp = q_exp.pop_front();
        m_tag = q_tag.pop_front();
        if (reg_rdata !== m_exp) begin
          bad++;
          $display("FAIL %s got=%h exp=%h", m_tag, reg_rdata, m_exp);
        end
      end
    end
  end

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    reg_rd = 1'b1; reg_addr = a;
    q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_pend(input string tag);
    for (int k = 0; k < 4; k++) rd(AW'(12'h810 + 4*k), DW'(m_pend[k]), tag);
  endtask

  task automatic read_gated(input string tag);
    for (int k = 0; k < 4; k++) rd(AW'(12'h800 + 4*k), DW'(m_pend[k] & irq_en), tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) m_pend[k] = '0;
    m_run = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(DW'(irq), 0, "R1 irq after reset");
    check(DW'(reg_rdata), 0, "R1 rdata after reset");
    read_pend("R1 pending after reset");
    rd(12'h820, 0, "R1 running after reset");
    rd(12'h824, 0, "R1 prio after reset");
    rd(12'h828, 0, "R1 arb after reset");

    // R2 events set pending bits, class to address mapping
    ev_tc = 8'h05; ev_src_err = 8'h20; ev_dst_err = 8'h80; ev_cfg_err = 8'h01;
    @(negedge clk);
    ev_tc = '0; ev_src_err = '0; ev_dst_err = '0; ev_cfg_err = '0;
    m_pend[0] = 8'h05; m_pend[1] = 8'h20; m_pend[2] = 8'h80; m_pend[3] = 8'h01;
    check(DW'(irq), 0, "R4 irq low with enables off");
    read_pend("R2 pending after events");
    read_gated("R3 gated with enables off");

    // R3 and R4 with partial enables
    irq_en = 8'h21;
    @(negedge clk);
    check(DW'(irq), 1, "R4 irq high after enable");
    read_gated("R3 gated with enables 21");

    // R5 write ones clears, zeros keep
    wr(12'h810, 32'h04); m_pend[0] = 8'h01;
    wr(12'h814, 32'h00);
    read_pend("R5 pending after clear writes");

    // R6 event and clear on same bit, same edge
    reg_wr = 1'b1; reg_addr = 12'h818; reg_wdata = 32'h82; ev_dst_err = 8'h80;
    @(negedge clk);
    reg_wr = 1'b0; ev_dst_err = '0;
    m_pend[2] = (m_pend[2] & ~8'h82) | 8'h80;
    rd(12'h818, DW'(m_pend[2]), "R6 event beats clear");

    // R11 writes to gated and status ignored
    wr(12'h800, 32'hFFFF_FFFF);
    wr(12'h80C, 32'hFFFF_FFFF);
    wr(12'h820, 32'hFFFF_FFFF);
    read_pend("R11 pending after read-only writes");
    rd(12'h820, 0, "R11 running after write");

    // R7 all ones clears everything
    for (int k = 0; k < 4; k++) wr(AW'(12'h810 + 4*k), 32'hFFFF_FFFF);
    for (int k = 0; k < 4; k++) m_pend[k] = '0;
    check(DW'(irq), 0, "R7 irq low after full clear");
    read_pend("R7 pending after full clear");

    // R4 rise on enabled event, drop on clear
    ev_cfg_err = 8'h20;
    @(negedge clk);
    ev_cfg_err = '0; m_pend[3] = 8'h20;
    check(DW'(irq), 1, "R4 irq on enabled event");
    wr(12'h81C, 32'h20); m_pend[3] = '0;
    check(DW'(irq), 0, "R4 irq after clear");

    // R8 launch and finish
    ch_launch = 8'h0F;
    @(negedge clk);
    ch_launch = '0; m_run = 8'h0F;
    rd(12'h820, DW'(m_run), "R8 running after launch");
    ch_finish = 8'h03; ch_launch = 8'h02;
    @(negedge clk);
    ch_finish = '0; ch_launch = '0; m_run = 8'h0E;
    rd(12'h820, DW'(m_run), "R8 launch beats finish");

    // R9 kill beats launch, and kill alone
    ch_kill = 8'h04; ch_launch = 8'h14;
    @(negedge clk);
    ch_kill = '0; ch_launch = '0; m_run = 8'h1A;
    rd(12'h820, DW'(m_run), "R9 kill beats launch");
    ch_kill = 8'h08;
    @(negedge clk);
    ch_kill = '0; m_run = 8'h12;
    rd(12'h820, DW'(m_run), "R9 kill clears next cycle");

    // R10 priority and arbitration registers
    wr(12'h824, 32'hFFFF_FFA5);
    check(DW'(grp_prio), 32'hA5, "R10 grp_prio output");
    rd(12'h824, 32'hA5, "R10 prio readback");
    wr(12'h828, 32'h0000_0013);
    check(DW'(arb_mode), 32'h3, "R10 arb_mode output");
    rd(12'h828, 32'h3, "R10 arb readback");
    wr(12'h828, 32'h0);
    check(DW'(arb_mode), 0, "R10 arb equal priority");

    // R12 unmapped reads and idle data
    rd(12'h82C, 0, "R12 unmapped 82C");
    rd(12'h000, 0, "R12 unmapped 000");
    @(negedge clk);
    check(reg_rdata, 0, "R12 rdata idle");

    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule